// File: doc/BRIEF.md
# Virtqueue control register bank

This block is the register file through which a driver sets up a paravirtual device. It sits behind a plain 32-bit read/write bus addressed in bytes, with one register per aligned word. It returns fixed identification words. It keeps a set of queue settings for each of `NUM_Q` queues. The driver picks which set the queue registers act on by writing a select register. Each ring location is a 64-bit address, written as two 32-bit halves.

Each queue has a ready bit. While that bit is set, the queue's ring addresses are frozen. The device engine reads the settings of any queue through a separate read-only port. A small byte-writable configuration window holds device-specific data. A generation counter lets the driver detect a configuration update that arrives between two reads. Two device-side event pulses set interrupt status bits. Those bits drive a single interrupt line and are cleared by a mask written to an acknowledge register.

Top module: `vq_regbank`

## Requirements
- R1: A read returns its data on `bus_rdata` one clock after the read cycle. `bus_rdata` is 0 after any cycle without a read. Offset 0x000 reads 0x74726976, offset 0x004 reads 2 and offset 0x008 reads the `DEV_TYPE` parameter.
- R2: Offset 0x030 is the write-only queue select. Offset 0x034 reads `QMAX` when the selected index is below `NUM_Q`, and 0 otherwise.
- R3: A write to offset 0x038 stores `bus_wdata[QSZ_W-1:0]` as the size of the selected queue. The stored size appears on `dev_qnum`.
- R4: Offset 0x03c holds the selected queue's ready bit, taken from `bus_wdata[0]`. It reads back as the last value written and appears on `dev_qready`. Every queue keeps its own bit.
- R5: The descriptor, available and used ring addresses are written as pairs of words. The low word is at 0x080, 0x090 or 0x0a0, and the high word is at 0x084, 0x094 or 0x0a4. Each pair forms one 64-bit address, shown on `dev_desc`, `dev_avail` and `dev_used`.
- R6: A ring-address write is discarded while the selected queue's ready bit is 1.
- R7: While the select value is `NUM_Q` or above, writes to the size, ready and ring registers are discarded, and the ready register reads 0.
- R8: The following reads return 0: misaligned offsets, unmapped offsets and the write-only registers (0x030, 0x038, 0x064, the ring halves). Writes to read-only offsets change nothing.
- R9: The configuration window starts at 0x100 and is `CFG_BYTES` long. Writes update only the byte lanes set in `bus_wstrb`, where bit n covers byte n. Reads return the whole word.
- R10: Offset 0x0fc reads the generation count, which is 0 after reset. An `evt_cfg` pulse increments it by one, but only if at least one configuration-window read has occurred since the last increment. A read in the same cycle as the pulse counts only toward the next increment.
- R11: Offset 0x060 reads the interrupt status. Bit 0 is set by `evt_used` and bit 1 by `evt_cfg`. A write to 0x064 clears the status bits set in `bus_wdata[1:0]`. An event in the same cycle as an acknowledge still sets its bit.
- R12: `irq` is high exactly when a status bit is set. It changes at the same clock edge as the status.
- R13: After reset the following are all 0: the select, every ready bit, size and ring address, the status, `irq` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte lane enables (used by the configuration window) |
| bus_rdata | output | 32 | Registered read data |
| evt_used | input | 1 | Device pulse: used buffer available |
| evt_cfg | input | 1 | Device pulse: configuration updated |
| irq | output | 1 | Interrupt line |
| dev_qidx | input | IDX_W | Queue index viewed by the device engine |
| dev_qnum | output | QSZ_W | Size of the viewed queue |
| dev_qready | output | 1 | Ready bit of the viewed queue |
| dev_desc | output | 64 | Descriptor ring address of the viewed queue |
| dev_avail | output | 64 | Available ring address of the viewed queue |
| dev_used | output | 64 | Used ring address of the viewed queue |

## Verification
Each result has its own latency:

- **Read data** is due on the clock after the read and reflects the state from before that edge.
- **Device view outputs** show state one edge after it is written, because they are registered from the stored settings.
- **Interrupt status and `irq`** change on the same edge as the event or acknowledge that causes them.

The bench drives every operation as one cycle. It predicts each output from the model state before the edge and applies the model update after the edge. It compares `bus_rdata`, `irq` and the whole device view one nanosecond after every rising edge, so a result that arrives one cycle early or late is reported.

// File: rtl/vq_pkg.sv
package vq_pkg;
  localparam logic [31:0] VQ_MAGIC   = 32'h7472_6976;
  localparam logic [31:0] VQ_VERSION = 32'd2;

  localparam int unsigned OFS_MAGIC    = 'h000;
  localparam int unsigned OFS_VER      = 'h004;
  localparam int unsigned OFS_DEVTYPE  = 'h008;
  localparam int unsigned OFS_QSEL     = 'h030;
  localparam int unsigned OFS_QMAX     = 'h034;
  localparam int unsigned OFS_QNUM     = 'h038;
  localparam int unsigned OFS_QRDY     = 'h03c;
  localparam int unsigned OFS_ISTAT    = 'h060;
  localparam int unsigned OFS_IACK     = 'h064;
  localparam int unsigned OFS_DESC_LO  = 'h080;
  localparam int unsigned OFS_DESC_HI  = 'h084;
  localparam int unsigned OFS_AVAIL_LO = 'h090;
  localparam int unsigned OFS_AVAIL_HI = 'h094;
  localparam int unsigned OFS_USED_LO  = 'h0a0;
  localparam int unsigned OFS_USED_HI  = 'h0a4;
  localparam int unsigned OFS_GEN      = 'h0fc;
  localparam int unsigned OFS_CFG      = 'h100;

  // one-hot positions of the six ring-address halves
  typedef enum int unsigned {
    RH_DESC_LO  = 0,
    RH_DESC_HI  = 1,
    RH_AVAIL_LO = 2,
    RH_AVAIL_HI = 3,
    RH_USED_LO  = 4,
    RH_USED_HI  = 5
  } ring_half_e;

  localparam int unsigned RING_HALVES = 6;
endpackage

// File: rtl/vq_queue_bank.sv
module vq_queue_bank import vq_pkg::*; #(
  parameter int unsigned NUM_Q = 4,
  parameter int unsigned QSZ_W = 9,
  parameter int unsigned IDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [31:0]            sel,
  input  logic                   wr_num,
  input  logic                   wr_rdy,
  input  logic [RING_HALVES-1:0] wr_ring,
  input  logic [31:0]            wdata,
  output logic                   sel_ok,
  output logic                   sel_ready,
  input  logic [IDX_W-1:0]       dev_idx,
  output logic [QSZ_W-1:0]       dev_num,
  output logic                   dev_rdy,
  output logic [63:0]            dev_desc,
  output logic [63:0]            dev_avail,
  output logic [63:0]            dev_used
);
  logic             rdy_a   [NUM_Q];
  logic [QSZ_W-1:0] num_a   [NUM_Q];
  logic [63:0]      desc_a  [NUM_Q];
  logic [63:0]      avail_a [NUM_Q];
  logic [63:0]      used_a  [NUM_Q];

  assign sel_ok = (sel < 32'(NUM_Q));

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic             rdy_r;
    logic [QSZ_W-1:0] num_r;
    logic [63:0]      desc_r, avail_r, used_r;
    logic             hit;

    assign hit = sel_ok && (sel == 32'(q));

    always_ff @(posedge clk) begin
      if (rst) begin
        rdy_r   <= 1'b0;
        num_r   <= '0;
        desc_r  <= '0;
        avail_r <= '0;
        used_r  <= '0;
      end else if (hit) begin
        if (wr_num) num_r <= wdata[QSZ_W-1:0];
        if (wr_rdy) rdy_r <= wdata[0];
        if (!rdy_r) begin
          if (wr_ring[RH_DESC_LO])  desc_r[31:0]   <= wdata;
          if (wr_ring[RH_DESC_HI])  desc_r[63:32]  <= wdata;
          if (wr_ring[RH_AVAIL_LO]) avail_r[31:0]  <= wdata;
          if (wr_ring[RH_AVAIL_HI]) avail_r[63:32] <= wdata;
          if (wr_ring[RH_USED_LO])  used_r[31:0]   <= wdata;
          if (wr_ring[RH_USED_HI])  used_r[63:32]  <= wdata;
        end
      end
    end

    assign rdy_a[q]   = rdy_r;
    assign num_a[q]   = num_r;
    assign desc_a[q]  = desc_r;
    assign avail_a[q] = avail_r;
    assign used_a[q]  = used_r;
  end

  assign sel_ready = sel_ok ? rdy_a[sel[IDX_W-1:0]] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst || !(32'(dev_idx) < 32'(NUM_Q))) begin
      dev_num   <= '0;
      dev_rdy   <= 1'b0;
      dev_desc  <= '0;
      dev_avail <= '0;
      dev_used  <= '0;
    end else begin
      dev_num   <= num_a[dev_idx];
      dev_rdy   <= rdy_a[dev_idx];
      dev_desc  <= desc_a[dev_idx];
      dev_avail <= avail_a[dev_idx];
      dev_used  <= used_a[dev_idx];
    end
  end
endmodule

// File: rtl/vq_cfg_space.sv
module vq_cfg_space #(
  parameter int unsigned CFG_WORDS = 4,
  parameter int unsigned CW_W      = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [CW_W-1:0] idx,
  input  logic [3:0]      wstrb,
  input  logic [31:0]     wdata,
  input  logic            evt_cfg,
  output logic [31:0]     rd_word,
  output logic [31:0]     gen
);
  logic [31:0] mem [CFG_WORDS];
  logic        seen_q;
  logic        bump;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (wstrb[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rd_word = mem[idx];
  assign bump    = evt_cfg && seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gen    <= '0;
      seen_q <= 1'b0;
    end else begin
      if (bump) gen <= gen + 32'd1;
      seen_q <= (seen_q && !bump) || rd_en;
    end
  end
endmodule

// File: rtl/vq_irq.sv
module vq_irq (
  input  logic       clk,
  input  logic       rst,
  input  logic       evt_used,
  input  logic       evt_cfg,
  input  logic       ack_en,
  input  logic [1:0] ack_mask,
  output logic [1:0] status,
  output logic       irq
);
  logic [1:0] status_d;

  always_comb begin
    status_d = status;
    if (ack_en) status_d = status_d & ~ack_mask;
    status_d = status_d | {evt_cfg, evt_used};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      irq    <= |status_d;
    end
  end
endmodule

// File: rtl/vq_regbank.sv
module vq_regbank import vq_pkg::*; #(
  parameter int unsigned NUM_Q     = 4,
  parameter int unsigned QMAX      = 256,
  parameter int unsigned CFG_BYTES = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [31:0] DEV_TYPE  = 32'd1,
  localparam int unsigned IDX_W     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int unsigned QSZ_W     = $clog2(QMAX + 1),
  localparam int unsigned CFG_WORDS = CFG_BYTES / 4,
  localparam int unsigned CW_W      = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_wstrb,
  output logic [31:0]       bus_rdata,
  input  logic              evt_used,
  input  logic              evt_cfg,
  output logic              irq,
  input  logic [IDX_W-1:0]  dev_qidx,
  output logic [QSZ_W-1:0]  dev_qnum,
  output logic              dev_qready,
  output logic [63:0]       dev_desc,
  output logic [63:0]       dev_avail,
  output logic [63:0]       dev_used
);
  logic [31:0]            qsel_q;
  logic                   in_cfg;
  logic [CW_W-1:0]        cfg_idx;
  logic [RING_HALVES-1:0] ring_hit;
  logic                   sel_ok, sel_ready;
  logic [31:0]            cfg_word, gen_w, rd_mux;
  logic [1:0]             istat;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign in_cfg  = (32'(bus_addr) >= OFS_CFG) && (32'(bus_addr) < OFS_CFG + CFG_BYTES);
  assign cfg_idx = CW_W'((32'(bus_addr) - OFS_CFG) >> 2);

  assign ring_hit[RH_DESC_LO]  = at(bus_addr, OFS_DESC_LO);
  assign ring_hit[RH_DESC_HI]  = at(bus_addr, OFS_DESC_HI);
  assign ring_hit[RH_AVAIL_LO] = at(bus_addr, OFS_AVAIL_LO);
  assign ring_hit[RH_AVAIL_HI] = at(bus_addr, OFS_AVAIL_HI);
  assign ring_hit[RH_USED_LO]  = at(bus_addr, OFS_USED_LO);
  assign ring_hit[RH_USED_HI]  = at(bus_addr, OFS_USED_HI);

  always_ff @(posedge clk) begin
    if (rst) qsel_q <= '0;
    else if (bus_wr && at(bus_addr, OFS_QSEL)) qsel_q <= bus_wdata;
  end

  vq_queue_bank #(.NUM_Q(NUM_Q), .QSZ_W(QSZ_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .sel       (qsel_q),
    .wr_num    (bus_wr && at(bus_addr, OFS_QNUM)),
    .wr_rdy    (bus_wr && at(bus_addr, OFS_QRDY)),
    .wr_ring   (bus_wr ? ring_hit : '0),
    .wdata     (bus_wdata),
    .sel_ok    (sel_ok),
    .sel_ready (sel_ready),
    .dev_idx   (dev_qidx),
    .dev_num   (dev_qnum),
    .dev_rdy   (dev_qready),
    .dev_desc  (dev_desc),
    .dev_avail (dev_avail),
    .dev_used  (dev_used)
  );

  vq_cfg_space #(.CFG_WORDS(CFG_WORDS), .CW_W(CW_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr && in_cfg),
    .rd_en   (bus_rd && in_cfg),
    .idx     (cfg_idx),
    .wstrb   (bus_wstrb),
    .wdata   (bus_wdata),
    .evt_cfg (evt_cfg),
    .rd_word (cfg_word),
    .gen     (gen_w)
  );

  vq_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .evt_used (evt_used),
    .evt_cfg  (evt_cfg),
    .ack_en   (bus_wr && at(bus_addr, OFS_IACK)),
    .ack_mask (bus_wdata[1:0]),
    .status   (istat),
    .irq      (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (in_cfg)                          rd_mux = cfg_word;
    else if (at(bus_addr, OFS_MAGIC))    rd_mux = VQ_MAGIC;
    else if (at(bus_addr, OFS_VER))      rd_mux = VQ_VERSION;
    else if (at(bus_addr, OFS_DEVTYPE))  rd_mux = DEV_TYPE;
    else if (at(bus_addr, OFS_QMAX))     rd_mux = sel_ok ? 32'(QMAX) : '0;
    else if (at(bus_addr, OFS_QRDY))     rd_mux = {31'd0, sel_ready};
    else if (at(bus_addr, OFS_ISTAT))    rd_mux = {30'd0, istat};
    else if (at(bus_addr, OFS_GEN))      rd_mux = gen_w;
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) bus_rdata <= '0;
    else                bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/vq_regbank_chk.sv
module vq_regbank_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              evt_used,
  input logic              evt_cfg,
  input logic              irq,
  input logic [31:0]       gen
);
  p_magic_word_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'('h000)) |=> (bus_rdata == 32'h7472_6976));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'('h0f0)) |=> (bus_rdata == 32'd0));

  p_event_raises_irq_r11: assert property (@(posedge clk) disable iff (rst)
    (evt_used || evt_cfg) |=> irq);

  p_full_ack_drops_irq_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'('h064) && bus_wdata[1:0] == 2'b11 && !evt_used && !evt_cfg)
      |=> !irq);

  p_gen_single_step_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(gen) |-> (gen == $past(gen) + 32'd1));

  p_gen_needs_event_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(gen) |-> $past(evt_cfg));
endmodule

bind vq_regbank vq_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .evt_used  (evt_used),
  .evt_cfg   (evt_cfg),
  .irq       (irq),
  .gen       (gen_w)
);

// File: tb/vq_regbank_test.sv
`timescale 1ns/1ps
module vq_regbank_test;
  localparam int NQ   = 4;
  localparam int QMAX = 256;
  localparam int CFGB = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_rdata;
  logic        evt_used = 0, evt_cfg = 0, irq;
  logic [1:0]  dev_qidx = '0;
  logic [8:0]  dev_qnum;
  logic        dev_qready;
  logic [63:0] dev_desc, dev_avail, dev_used;

  always #2.5 clk = ~clk;

  vq_regbank uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
    .evt_used(evt_used), .evt_cfg(evt_cfg), .irq(irq), .dev_qidx(dev_qidx),
    .dev_qnum(dev_qnum), .dev_qready(dev_qready), .dev_desc(dev_desc),
    .dev_avail(dev_avail), .dev_used(dev_used)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  longint unsigned m_sel;
  bit              m_rdy   [NQ];
  int unsigned     m_num   [NQ];
  longint unsigned m_desc  [NQ];
  longint unsigned m_avail [NQ];
  longint unsigned m_used  [NQ];
  byte unsigned    m_cfg   [CFGB];
  int unsigned     m_gen;
  bit              m_seen;
  bit [1:0]        m_st;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int unsigned mread(input int unsigned a);
    if (a >= 'h100 && a < 'h100 + CFGB) begin
      int unsigned b = (a - 'h100) & ~32'd3;
      return {m_cfg[b+3], m_cfg[b+2], m_cfg[b+1], m_cfg[b]};
    end
    case (a)
      'h000: return 32'h7472_6976;
      'h004: return 2;
      'h008: return 1;
      'h034: return (m_sel < NQ) ? QMAX : 0;
      'h03c: return (m_sel < NQ) ? int'(m_rdy[m_sel]) : 0;
      'h060: return m_st;
      'h0fc: return m_gen;
      default: return 0;
    endcase
  endfunction

  task automatic mwrite(input int unsigned a, input int unsigned d, input bit [3:0] s);
    bit ok = (m_sel < NQ);
    if (a >= 'h100 && a < 'h100 + CFGB) begin
      int unsigned b = (a - 'h100) & ~32'd3;
      for (int k = 0; k < 4; k++) if (s[k]) m_cfg[b+k] = d[8*k +: 8];
      return;
    end
    case (a)
      'h030: m_sel = d;
      'h038: if (ok) m_num[m_sel] = d & 32'h1ff;
      'h03c: if (ok) m_rdy[m_sel] = d[0];
      'h064: m_st = m_st & ~d[1:0];
      default: if (ok && !m_rdy[m_sel]) begin
        case (a)
          'h080: m_desc[m_sel][31:0]   = d;
          'h084: m_desc[m_sel][63:32]  = d;
          'h090: m_avail[m_sel][31:0]  = d;
          'h094: m_avail[m_sel][63:32] = d;
          'h0a0: m_used[m_sel][31:0]   = d;
          'h0a4: m_used[m_sel][63:32]  = d;
          default: ;
        endcase
      end
    endcase
  endtask

  // one bus cycle; outputs compared 1 ns after the edge
  task automatic step(input bit wr, input bit rd, input int unsigned a,
                      input int unsigned d, input bit [3:0] s,
                      input bit eu, input bit ec, input string tag);
    int unsigned exp_rd;
    int unsigned e_num; bit e_rdy; longint unsigned e_d, e_a, e_u;
    bit inc, cfg_rd;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a[11:0]; bus_wdata = d; bus_wstrb = s;
    evt_used = eu; evt_cfg = ec;
    exp_rd = rd ? mread(a) : 0;
    e_num = m_num[dev_qidx]; e_rdy = m_rdy[dev_qidx];
    e_d = m_desc[dev_qidx]; e_a = m_avail[dev_qidx]; e_u = m_used[dev_qidx];
    @(posedge clk);
    cfg_rd = rd && a >= 'h100 && a < 'h100 + CFGB;
    inc = ec && m_seen;
    m_seen = (m_seen && !inc) || cfg_rd;
    if (inc) m_gen++;
    if (wr) mwrite(a, d, s);
    m_st = m_st | {ec, eu};
    #1;
    chk(bus_rdata == exp_rd, tag, "rdata", bus_rdata, exp_rd);
    chk(irq == (m_st != 0), tag, "irq", irq, m_st != 0);
    chk(dev_qnum == e_num && dev_qready == e_rdy, tag, "dev num/ready",
        {dev_qnum, dev_qready}, {e_num[8:0], e_rdy});
    chk(dev_desc == e_d && dev_avail == e_a && dev_used == e_u, tag, "dev rings",
        dev_desc ^ dev_avail ^ dev_used, e_d ^ e_a ^ e_u);
  endtask

  task automatic wr(input int unsigned a, input int unsigned d, input string tag);
    step(1, 0, a, d, 4'hf, 0, 0, tag);
  endtask
  task automatic rd(input int unsigned a, input string tag);
    step(0, 1, a, 0, 4'h0, 0, 0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 0, 0, 4'h0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    m_sel = 0; m_gen = 0; m_seen = 0; m_st = 0;
    for (int q = 0; q < NQ; q++) begin
      m_rdy[q] = 0; m_num[q] = 0; m_desc[q] = 0; m_avail[q] = 0; m_used[q] = 0;
    end
    for (int b = 0; b < CFGB; b++) m_cfg[b] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R13: reset state
    idle("R13"); rd('h03c, "R13"); rd('h060, "R13"); rd('h0fc, "R13");
    // R1: identification words
    rd('h000, "R1"); rd('h004, "R1"); rd('h008, "R1");
    // R2: queue maximum per selection
    rd('h034, "R2"); wr('h030, 5, "R2"); rd('h034, "R2");
    wr('h030, 3, "R2"); rd('h034, "R2");
    // R3, R5: program queue 1
    dev_qidx = 1;
    wr('h030, 1, "R3"); wr('h038, 100, "R3");
    wr('h080, 32'h1000_0040, "R5"); wr('h084, 32'h0000_0002, "R5");
    wr('h090, 32'h2000_0080, "R5"); wr('h094, 32'h0000_0003, "R5");
    wr('h0a0, 32'h3000_1000, "R5"); wr('h0a4, 32'h0000_0004, "R5");
    idle("R5"); idle("R3");
    // R4: ready enable and read back, per queue
    wr('h03c, 1, "R4"); rd('h03c, "R4"); idle("R4");
    // R6: ring writes ignored while ready
    wr('h080, 32'hdead_beef, "R6"); wr('h0a4, 32'hffff_ffff, "R6"); idle("R6"); idle("R6");
    wr('h030, 2, "R4"); rd('h03c, "R4");
    wr('h030, 1, "R4"); wr('h03c, 0, "R4"); rd('h03c, "R4");
    wr('h090, 32'h5555_0000, "R6"); idle("R6"); idle("R6");
    // R7: out-of-range select
    wr('h030, 7, "R7"); wr('h038, 33, "R7"); wr('h03c, 1, "R7");
    wr('h080, 32'h77, "R7"); rd('h03c, "R7"); rd('h034, "R7");
    for (int q = 0; q < NQ; q++) begin
      dev_qidx = q[1:0]; idle("R7"); idle("R7");
    end
    // R8: unmapped, write-only, misaligned, read-only writes
    wr('h030, 0, "R8");
    rd('h0f0, "R8"); rd('h030, "R8"); rd('h038, "R8"); rd('h080, "R8");
    rd('h064, "R8"); rd('h001, "R8");
    wr('h000, 32'h1234, "R8"); rd('h000, "R8");
    wr('h034, 5, "R8"); rd('h034, "R8");
    // R9: byte-lane configuration writes
    step(1, 0, 'h100, 32'haabbccdd, 4'hf, 0, 0, "R9");
    step(1, 0, 'h104, 32'h11223344, 4'hf, 0, 0, "R9");
    step(1, 0, 'h108, 32'h0, 4'hf, 0, 0, "R9");
    step(1, 0, 'h10c, 32'h0, 4'hf, 0, 0, "R9");
    step(1, 0, 'h100, 32'h99887766, 4'b0101, 0, 0, "R9");
    rd('h100, "R9"); rd('h104, "R9");
    step(1, 0, 'h10c, 32'hcafe_f00d, 4'b1000, 0, 0, "R9"); rd('h10c, "R9");
    // R10: generation counter rule (no R11 irq leak: acks below)
    step(0, 0, 0, 0, 0, 0, 1, "R10"); rd('h0fc, "R10");
    rd('h108, "R10"); step(0, 0, 0, 0, 0, 0, 1, "R10"); rd('h0fc, "R10");
    step(0, 0, 0, 0, 0, 0, 1, "R10"); rd('h0fc, "R10");
    step(0, 1, 'h104, 0, 0, 0, 1, "R10"); rd('h0fc, "R10");
    step(0, 0, 0, 0, 0, 0, 1, "R10"); rd('h0fc, "R10");
    // R11, R12: interrupt status and line
    wr('h064, 3, "R12"); rd('h060, "R11");
    step(0, 0, 0, 0, 0, 1, 0, "R11"); rd('h060, "R11");
    wr('h064, 2, "R11"); rd('h060, "R11");
    wr('h064, 1, "R12"); idle("R12");
    step(0, 0, 0, 0, 0, 1, 1, "R11"); rd('h060, "R11");
    step(1, 0, 'h064, 3, 4'hf, 1, 0, "R11"); rd('h060, "R11");
    wr('h064, 3, "R12"); idle("R12");
    finish_run();
  end
endmodule